// File: doc/BRIEF.md
# Selectable-Width Up/Down Counter

This block is a general-purpose counter whose active width can be set to 10, 8, 6 or 4 bits while it runs. It steps up or down once for each pulse from a chosen count source. Six of the sources are single-cycle enable strobes made elsewhere on the chip. The other two are asynchronous event pins, which the block synchronises and edge-detects itself. The bits above the chosen width are held and take no part in counting. When the active part reaches its terminal value, the counter reloads the start value that was last written and carries on.

A register port writes the control word, the start value and the compare value, and reads any of them back. Writing the start value also loads it into the counter at once. The count is checked against the compare value either over all 10 bits or over the active width only. The block gives a one-cycle strobe when a step makes the count equal to the compare value, and another when a step makes the active count zero. A PWM output is high while the active count is below the active compare value, so one counter serves as timer, event counter or PWM source.

Top module: `flexwidth_counter`

## Requirements
- R1: Control field `wsel` (control bits [1:0]) sets the active width: 0 gives 10 bits, 1 gives 8, 2 gives 6 and 3 gives 4. A count step changes only the active low bits and leaves the count bits above them unchanged.
- R2: With control bit [2] clear, a step increments the active count, and a step taken at all-ones loads the active bits of the start value. With bit [2] set, a step decrements, and a step taken at zero loads the active bits of the start value.
- R3: A write to address 1 stores the full 10-bit value as the start value and places it in the counter on the same clock edge. This takes priority over a step in that cycle.
- R4: Control bits [5:3] pick the count source. Values 0 to 5 pick `tick_src[0..5]`, value 6 picks `evt_pin[0]` and value 7 picks `evt_pin[1]`. An event pin passes through two synchronising flip-flops and gives exactly one step per rising edge, so the count changes on the third rising clock edge after the pin rises. Sources that are not selected have no effect.
- R5: `irq_cmp` is high for the one cycle after a step whose result equals the compare value (address 2). With control bit [6] clear the comparison uses all 10 bits; with it set, only the active bits are compared.
- R6: `irq_zero` is high for the one cycle after a step whose result has an active part of zero. A parallel load never raises it.
- R7: `pwm_out` equals control bit [8] ANDed with (active count < active compare value).
- R8: While control bit [7] (run) is clear, source pulses cause no steps: the count holds and neither strobe fires.
- R9: After reset, the count, start value, compare value and control word are zero, and `irq_cmp`, `irq_zero` and `pwm_out` are low.
- R10: `reg_rdata` shows the control word at address 0, the start value at address 1, the compare value at address 2 and the live count at address 3. Unused control bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 10 | Register write data |
| reg_rdata | output | 10 | Register read data for `reg_addr` |
| tick_src | input | 6 | On-chip count enables, one cycle per pulse |
| evt_pin | input | 2 | Asynchronous event pins |
| irq_cmp | output | 1 | Compare-match strobe |
| irq_zero | output | 1 | Zero-reached strobe |
| pwm_out | output | 1 | Pulse-width-modulated output |

## Verification
A wrong count or direction shows on the count readback on the edge of the faulty step. The bench reads the count after every step, so a fault is caught within one step. A wrong terminal or reload decision shows on the step after the active part reaches all-ones or zero, both as a wrong count and as a missing or extra zero strobe. A compare fault shows as a strobe in the wrong cycle or a PWM level that differs from the arithmetic expectation in the same cycle. A synchroniser fault shows as a count that changes one edge early or late, or that steps more than once while a pin stays high.

// File: rtl/fwc_pkg.sv
package fwc_pkg;
    // control word, bit 8 down to bit 0
    typedef struct packed {
        logic       pwm_en;   // [8]
        logic       run;      // [7]
        logic       limited;  // [6]
        logic [2:0] src;      // [5:3]
        logic       down;     // [2]
        logic [1:0] wsel;     // [1:0]
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_RELOAD = 2'd1;
    localparam logic [1:0] ADDR_CMP    = 2'd2;
    localparam logic [1:0] ADDR_COUNT  = 2'd3;
endpackage

// File: rtl/fwc_regs.sv
module fwc_regs
    import fwc_pkg::*;
#(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    addr,
    input  logic [CW-1:0] wdata,
    output ctrl_t         ctrl,
    output logic [CW-1:0] reload,
    output logic [CW-1:0] cmpv,
    output logic          load
);
    typedef struct packed {
        ctrl_t         ctrl;
        logic [CW-1:0] reload;
        logic [CW-1:0] cmpv;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (addr)
                ADDR_CTRL:   r_d.ctrl   = ctrl_t'(wdata[CTRL_W-1:0]);
                ADDR_RELOAD: r_d.reload = wdata;
                ADDR_CMP:    r_d.cmpv   = wdata;
                default:     r_d        = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl   = r_q.ctrl;
    assign reload = r_q.reload;
    assign cmpv   = r_q.cmpv;
    assign load   = we && (addr == ADDR_RELOAD);
endmodule

// File: rtl/fwc_evsync.sv
module fwc_evsync #(
    parameter int NPIN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin,
    output logic [NPIN-1:0] rise
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        typedef struct packed {
            logic s1;
            logic s2;
            logic s3;
        } sync_t;

        sync_t s_d, s_q;

        always_comb begin
            s_d.s1 = pin[i];
            s_d.s2 = s_q.s1;
            s_d.s3 = s_q.s2;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= s_d;
        end

        assign rise[i] = s_q.s2 && !s_q.s3;
    end
endmodule

// File: rtl/fwc_core.sv
module fwc_core
    import fwc_pkg::*;
#(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctrl_t         ctrl,
    input  logic          step,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic [CW-1:0] reload,
    input  logic [CW-1:0] cmpv,
    output logic [CW-1:0] cnt,
    output logic          irq_cmp,
    output logic          irq_zero,
    output logic          pwm
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          irq_cmp;
        logic          irq_zero;
    } core_t;

    core_t c_d, c_q;

    logic [CW-1:0] mask;
    logic [CW-1:0] act;
    logic [CW-1:0] act_nxt;
    logic [CW-1:0] nxt;
    logic          at_end;

    always_comb begin
        mask   = {CW{1'b1}} >> (2 * ctrl.wsel);
        act    = c_q.cnt & mask;
        at_end = ctrl.down ? (act == '0) : (act == mask);
        if (at_end)         act_nxt = reload & mask;
        else if (ctrl.down) act_nxt = (act - 1'b1) & mask;
        else                act_nxt = (act + 1'b1) & mask;
        nxt = (c_q.cnt & ~mask) | act_nxt;
    end

    always_comb begin
        c_d          = c_q;
        c_d.irq_cmp  = 1'b0;
        c_d.irq_zero = 1'b0;
        if (load) begin
            c_d.cnt = load_val;
        end else if (step) begin
            c_d.cnt      = nxt;
            c_d.irq_zero = (act_nxt == '0);
            c_d.irq_cmp  = ctrl.limited ? (act_nxt == (cmpv & mask)) : (nxt == cmpv);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt      = c_q.cnt;
    assign irq_cmp  = c_q.irq_cmp;
    assign irq_zero = c_q.irq_zero;
    assign pwm      = ctrl.pwm_en && (act < (cmpv & mask));
endmodule

// File: rtl/flexwidth_counter.sv
module flexwidth_counter
    import fwc_pkg::*;
#(
    parameter int CW   = 10,
    parameter int NTCK = 6,
    parameter int NEVT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [1:0]      reg_addr,
    input  logic [CW-1:0]   reg_wdata,
    output logic [CW-1:0]   reg_rdata,
    input  logic [NTCK-1:0] tick_src,
    input  logic [NEVT-1:0] evt_pin,
    output logic            irq_cmp,
    output logic            irq_zero,
    output logic            pwm_out
);
    localparam int NSRC = NTCK + NEVT;

    ctrl_t           ctrl_w;
    logic [CW-1:0]   reload_w;
    logic [CW-1:0]   cmpv_w;
    logic [CW-1:0]   cnt_w;
    logic            load_w;
    logic            step_w;
    logic [NEVT-1:0] evt_rise;
    logic [NSRC-1:0] srcs;

    fwc_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .ctrl(ctrl_w), .reload(reload_w),
        .cmpv(cmpv_w), .load(load_w)
    );

    fwc_evsync #(.NPIN(NEVT)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(evt_pin), .rise(evt_rise)
    );

    assign srcs   = {evt_rise, tick_src};
    assign step_w = ctrl_w.run && srcs[ctrl_w.src];

    fwc_core #(.CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl_w), .step(step_w),
        .load(load_w), .load_val(reg_wdata), .reload(reload_w),
        .cmpv(cmpv_w), .cnt(cnt_w), .irq_cmp(irq_cmp),
        .irq_zero(irq_zero), .pwm(pwm_out)
    );

    always_comb begin
        case (reg_addr)
            ADDR_CTRL:   reg_rdata = CW'(ctrl_w);
            ADDR_RELOAD: reg_rdata = reload_w;
            ADDR_CMP:    reg_rdata = cmpv_w;
            default:     reg_rdata = cnt_w;
        endcase
    end
endmodule

// File: rtl/fwc_checker.sv
module fwc_checker #(
    parameter int CW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          step,
    input logic          load,
    input logic [CW-1:0] wdata,
    input logic [CW-1:0] cnt,
    input logic [1:0]    wsel,
    input logic          pwm_en,
    input logic          irq_cmp,
    input logic          irq_zero,
    input logic          pwm
);
    logic [CW-1:0] mask;
    assign mask = {CW{1'b1}} >> (2 * wsel);

    // R1: bits above the active width survive a step
    a_r1_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> ((cnt & ~$past(mask)) == ($past(cnt) & ~$past(mask))));

    // R3: a start-value write lands in the counter
    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(wdata)));

    // R5: compare strobe only follows a step
    a_r5_cmp_after_step: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cmp |-> $past(step && !load));

    // R6: zero strobe only follows a step, and the count is zero in its active part
    a_r6_zero_after_step: assert property (@(posedge clk) disable iff (!rst_n)
        irq_zero |-> $past(step && !load));

    a_r6_zero_value: assert property (@(posedge clk) disable iff (!rst_n)
        irq_zero |-> ((cnt & $past(mask)) == '0));

    // R8: no step and no load means the count holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(cnt));

    // R7: PWM is silent when disabled
    a_r7_pwm_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_en |-> !pwm);
endmodule

bind flexwidth_counter fwc_checker #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .step(step_w), .load(load_w),
    .wdata(reg_wdata), .cnt(cnt_w), .wsel(ctrl_w.wsel),
    .pwm_en(ctrl_w.pwm_en), .irq_cmp(irq_cmp), .irq_zero(irq_zero),
    .pwm(pwm_out)
);

// File: tb/flexwidth_counter_test.sv
module flexwidth_counter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd3;
    logic [9:0] reg_wdata = '0;
    logic [9:0] reg_rdata;
    logic [5:0] tick_src = '0;
    logic [1:0] evt_pin = '0;
    logic       irq_cmp, irq_zero, pwm_out;

    int total = 0;
    int fails = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    flexwidth_counter uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_src(tick_src),
        .evt_pin(evt_pin), .irq_cmp(irq_cmp), .irq_zero(irq_zero),
        .pwm_out(pwm_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] mkctrl(int w, bit dn, int src, bit lim, bit run, bit pe);
        return {pe, run, lim, 3'(src), dn, 2'(w)};
    endfunction

    function automatic logic [9:0] mstep(logic [9:0] c, int w, bit dn, logic [9:0] ld);
        logic [9:0] m, a, na;
        m = 10'h3FF >> (2 * w);
        a = c & m;
        if (dn) na = (a == 0) ? (ld & m) : ((a - 1) & m);
        else    na = (a == m) ? (ld & m) : ((a + 1) & m);
        return (c & ~m) | na;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [9:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 2'd3;
    endtask

    task automatic tick(input int idx);
        @(negedge clk);
        tick_src[idx] = 1'b1;
        @(negedge clk);
        tick_src = '0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [9:0] cur, ld, cm, m;
        bit lim;
        int hits;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 count", reg_rdata, 0);
        chk("R9 irq_cmp", irq_cmp, 0);
        chk("R9 irq_zero", irq_zero, 0);
        chk("R9 pwm", pwm_out, 0);
        reg_addr = 2'd0; #1;
        chk("R9 ctrl", reg_rdata, 0);
        reg_addr = 2'd3;

        // R1 R2 R5 R6 R7 sweep over widths, directions, compare modes
        for (int w = 0; w < 4; w++) begin
            for (int dn = 0; dn < 2; dn++) begin
                m   = 10'h3FF >> (2 * w);
                lim = w[0] ^ dn[0];
                ld  = 10'h2A5 ^ 10'(w * 37);
                cm  = (ld & ~m) | ((ld + 10'd5) & m);
                wr(2'd0, mkctrl(w, dn[0], 0, lim, 1, 1));
                wr(2'd2, cm);
                wr(2'd1, ld);
                cur = ld;
                chk("R3 load", reg_rdata, ld);
                for (int s = 0; s < int'(m) + 6; s++) begin
                    tick(0);
                    cur = mstep(cur, w, dn[0], ld);
                    chk("R1 R2 count", reg_rdata, cur);
                    chk("R6 irq_zero", irq_zero, ((cur & m) == 0));
                    chk("R5 irq_cmp", irq_cmp,
                        lim ? ((cur & m) == (cm & m)) : (cur == cm));
                    chk("R7 pwm", pwm_out, ((cur & m) < (cm & m)));
                end
            end
        end

        // R5 full compare misses when upper bits differ, limited hits
        wr(2'd0, mkctrl(3, 0, 0, 0, 1, 0));
        wr(2'd2, 10'h007);
        wr(2'd1, 10'h3F0);
        hits = 0;
        for (int s = 0; s < 20; s++) begin
            tick(0);
            hits += irq_cmp;
        end
        chk("R5 full compare no hit", hits, 0);
        chk("R7 pwm disabled", pwm_out, 0);
        wr(2'd0, mkctrl(3, 0, 0, 1, 1, 0));
        wr(2'd1, 10'h3F0);
        hits = 0;
        for (int s = 0; s < 16; s++) begin
            tick(0);
            hits += irq_cmp;
        end
        chk("R5 limited compare one hit", hits, 1);

        // R8 run clear ignores ticks
        wr(2'd0, mkctrl(0, 0, 0, 1, 0, 0));
        wr(2'd1, 10'h123);
        for (int s = 0; s < 5; s++) begin
            tick(0);
            chk("R8 hold count", reg_rdata, 10'h123);
            chk("R8 no irq", irq_cmp | irq_zero, 0);
        end

        // R4 event pin 0, synchroniser latency and one step per edge
        wr(2'd0, mkctrl(0, 0, 6, 0, 1, 0));
        wr(2'd1, 10'h010);
        @(negedge clk); evt_pin[0] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R4 evt not yet", reg_rdata, 10'h010);
        @(negedge clk);
        chk("R4 evt third edge", reg_rdata, 10'h011);
        repeat (5) @(negedge clk);
        chk("R4 one per edge", reg_rdata, 10'h011);
        tick(0);
        evt_pin[1] = 1'b1;
        repeat (5) @(negedge clk);
        chk("R4 unselected ignored", reg_rdata, 10'h011);
        evt_pin = '0;
        repeat (4) @(negedge clk);
        evt_pin[0] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R4 second edge", reg_rdata, 10'h012);
        evt_pin = '0;
        // R4 event pin 1 via source 7, and tick source 5
        wr(2'd0, mkctrl(0, 1, 7, 0, 1, 0));
        repeat (4) @(negedge clk);
        evt_pin[1] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R4 pin1 down", reg_rdata, 10'h011);
        evt_pin = '0;
        wr(2'd0, mkctrl(0, 0, 5, 0, 1, 0));
        tick(5);
        chk("R4 tick5", reg_rdata, 10'h012);
        tick(4);
        chk("R4 tick4 ignored", reg_rdata, 10'h012);

        // R3 load wins over a step in the same cycle
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 10'h200; tick_src[5] = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 2'd3; tick_src = '0;
        chk("R3 load priority", reg_rdata, 10'h200);

        // R10 readback
        wr(2'd2, 10'h155);
        wr(2'd0, 10'h3FF);
        reg_addr = 2'd0; #1;
        chk("R10 ctrl", reg_rdata, 10'h1FF);
        reg_addr = 2'd1; #1;
        chk("R10 reload", reg_rdata, 10'h200);
        reg_addr = 2'd2; #1;
        chk("R10 cmp", reg_rdata, 10'h155);
        reg_addr = 2'd3;
        finish_run();
    end
endmodule